// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block steps one transfer descriptor through three nested counts: a byte length for each array, a number of arrays in each frame, and a number of frames in the block. It does not move data. For every array it hands a data mover one request with a source address, a destination address and a byte length, over a valid/ready handshake. Between arrays it adds a signed per-array offset to each address. Between frames it adds a signed per-frame offset, and each direction has its own pair of offsets.

Sync event pulses pace the descriptor. A mode bit in the option word decides how much work one event releases. In array-paced mode one event releases one array. In frame-paced mode one event releases a whole frame, issued back to back. If an event arrives while work is still in flight, one pending flag remembers it. When the last array has been accepted the block goes idle. If the option word enables it, the block also pulses a completion strobe that carries a 6-bit code.

Top module: `dma3d_walker`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `req_valid`, `busy` and `done_strobe` are all low.
- R2: Each request carries the latched byte count on `req_len`. While `req_valid` is high and `req_ready` is low, the request stays valid and its addresses do not change.
- R3: In array-paced mode (option bit 0 = 0), each accepted sync event releases exactly one request. `req_valid` is low in the cycle after every handshake.
- R4: In frame-paced mode (option bit 0 = 1), one sync event releases every array of the current frame, with no further event needed. After the last array of a frame, `req_valid` drops until the next event.
- R5: Within a frame, each next array address equals the previous one plus the sign-extended per-array offset. The source offset is bits 15:0 of `desc_aofs` and the destination offset is bits 31:16.
- R6: The first array of a new frame adds the sign-extended per-frame offset to a base. The source offset is bits 15:0 of `desc_fofs` and the destination offset is bits 31:16. The base is the last array's address in array-paced mode and the frame's first address in frame-paced mode. With both offsets zero, every access hits the same address.
- R7: The first frame has `desc_bcnt` arrays. Every later frame has `desc_brld` arrays in array-paced mode and `desc_bcnt` arrays in frame-paced mode. All counts are at least one.
- R8: When option bit 1 is set, the destination address stays at its loaded value for the whole block. `req_dst_const` is high. `req_fifo_width` carries option bits 10:8.
- R9: In the cycle after the final handshake, `done_strobe` is high for one cycle if option bit 20 is set. `done_code` then equals option bits 17:12. With bit 20 clear, no strobe is given.
- R10: A sync event that arrives while a request is outstanding is held in one pending flag. That flag later releases work with no new event. Sync events while no descriptor is armed have no effect.
- R11: `busy` rises in the cycle after the first accepted event and stays high until completion. `busy` is low in the cycle that `done_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_load | input | 1 | Latch descriptor fields (taken only when not busy) |
| desc_opt | input | 32 | Option word: mode, constant destination, FIFO width, code, completion enable |
| desc_src | input | 32 | Source start address |
| desc_dst | input | 32 | Destination start address |
| desc_acnt | input | 16 | Bytes per array |
| desc_bcnt | input | 16 | Arrays in the first frame |
| desc_ccnt | input | 16 | Frames per block |
| desc_brld | input | 16 | Array count reloaded for later frames in array-paced mode |
| desc_aofs | input | 32 | Per-array offsets: source low half, destination high half |
| desc_fofs | input | 32 | Per-frame offsets: source low half, destination high half |
| sync_evt | input | 1 | Sync event pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Data mover accepts the request |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_len | output | 16 | Bytes in the array |
| req_dst_const | output | 1 | Destination is a fixed-address FIFO |
| req_fifo_width | output | 3 | FIFO access width code |
| done_strobe | output | 1 | One-cycle completion pulse |
| done_code | output | 6 | Completion code, valid with the strobe |
| busy | output | 1 | Block in progress |

## Verification
The bench targets three corner cases. The first is the frame-boundary base: a design that applied the frame offset from the wrong base would put every second frame at a shifted address in one of the two modes. The second is the array-count reload: a design that ignored it, or used it in frame-paced mode, would issue the wrong number of requests per frame. The third is an event that lands while a request is still stalled: a design without the pending flag would hang waiting for work it dropped. The bench also holds the data mover back on purpose, which catches addresses that move before the handshake. It uses a constant-FIFO destination with nonzero offsets, which catches a destination that walks. It checks negative offsets, which catches a missing sign extension.

// File: rtl/dw_pkg.sv
// Package: shared constants and state type for the 3-D address sequencer.
// Assumes a 32-bit option word; bit positions here are the block's own map,
// except the FIFO width field, which sits at bits 10:8.
package dw_pkg;
    localparam int OPT_FRAME_SYNC = 0;   // 1 = one event per frame
    localparam int OPT_DST_CONST  = 1;   // destination is a fixed FIFO
    localparam int OPT_FW_LSB     = 8;   // FIFO width, 3 bits
    localparam int OPT_FW_W       = 3;
    localparam int OPT_CODE_LSB   = 12;  // completion code, 6 bits
    localparam int OPT_CODE_W     = 6;
    localparam int OPT_DONE_EN    = 20;  // completion strobe enable

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no descriptor armed
        ST_ARMED = 2'd1,   // descriptor loaded, awaiting first event
        ST_ISSUE = 2'd2,   // request presented to data mover
        ST_WAIT  = 2'd3    // between events, block unfinished
    } walk_state_e;
endpackage

// File: rtl/dw_ctrl.sv
// Module: dw_ctrl
// Sequencing state machine. Turns sync events into request cycles, holds one
// pending event, and signals completion. Assumes the count walker reports
// last-array / last-frame for the request currently presented.
module dw_ctrl
    import dw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic desc_load,
    input  logic sync_evt,
    input  logic req_ready,
    input  logic last_arr,
    input  logic last_frm,
    input  logic frame_sync,
    input  logic done_en,
    output logic load_ok,
    output logic step,
    output logic req_valid,
    output logic busy,
    output logic done_strobe
);
    walk_state_e state;
    logic        pend;
    logic        done_q;

    // Decode outputs from state
    always_comb begin
        req_valid   = (state == ST_ISSUE);
        busy        = (state == ST_ISSUE) || (state == ST_WAIT);
        load_ok     = desc_load && ((state == ST_IDLE) || (state == ST_ARMED));
        step        = req_valid && req_ready;
        done_strobe = done_q;
    end

    // State, pending flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    pend <= 1'b0;
                    if (desc_load) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (!desc_load && sync_evt) state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (sync_evt) pend <= 1'b1;
                    if (req_ready) begin
                        if (last_arr && last_frm) begin
                            state  <= ST_IDLE;
                            pend   <= 1'b0;
                            done_q <= done_en;
                        end else if (!frame_sync || last_arr) begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (pend || sync_evt) begin
                        state <= ST_ISSUE;
                        pend  <= pend && sync_evt;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid); // R2
    AST_ONE_PER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        step && !frame_sync |=> !req_valid); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_strobe |-> !busy); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_strobe |=> !done_strobe); // R9
    AST_BUSY_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sync_evt)); // R11
endmodule

// File: rtl/dw_count.sv
// Module: dw_count
// Array and frame down-counters. Reports whether the presented request is
// the last array of its frame and whether that frame is the last one.
// Assumes all loaded counts, including the reload value, are nonzero.
module dw_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] bcnt,
    input  logic [CNT_W-1:0] ccnt,
    input  logic [CNT_W-1:0] brld,
    input  logic             frame_sync,
    input  logic             step,
    input  logic             active,
    output logic             last_arr,
    output logic             last_frm
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] b_left, c_left, bcnt_q, brld_q;

    // Last-element flags
    always_comb begin
        last_arr = (b_left == ONE);
        last_frm = (c_left == ONE);
    end

    // Count down per accepted array; reload arrays at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_left <= ONE;
            c_left <= ONE;
            bcnt_q <= ONE;
            brld_q <= ONE;
        end else if (load) begin
            b_left <= bcnt;
            c_left <= ccnt;
            bcnt_q <= bcnt;
            brld_q <= brld;
        end else if (step) begin
            if (last_arr) begin
                b_left <= frame_sync ? bcnt_q : brld_q;
                c_left <= c_left - ONE;
            end else begin
                b_left <= b_left - ONE;
            end
        end
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (b_left != '0) && (c_left != '0)); // R7
endmodule

// File: rtl/dw_addr.sv
// Module: dw_addr
// One address walker (source or destination). Advances by a signed array
// offset inside a frame and by a signed frame offset at frame ends, from the
// last array (array-paced) or from the frame start (frame-paced).
// Assumes ADDR_W > OFS_W.
module dw_addr #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  arr_ofs,
    input  logic [OFS_W-1:0]  frm_ofs,
    input  logic              frame_sync,
    input  logic              hold,
    input  logic              step,
    input  logic              last_arr,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] cur, frm_start, arr_ext, frm_ext, nxt_frame;
    logic [OFS_W-1:0]  arr_ofs_q, frm_ofs_q;

    // Sign extension and next-frame base
    always_comb begin
        arr_ext   = {{EXT_W{arr_ofs_q[OFS_W-1]}}, arr_ofs_q};
        frm_ext   = {{EXT_W{frm_ofs_q[OFS_W-1]}}, frm_ofs_q};
        nxt_frame = (frame_sync ? frm_start : cur) + frm_ext;
        addr      = cur;
    end

    // Address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            frm_start <= '0;
            arr_ofs_q <= '0;
            frm_ofs_q <= '0;
        end else if (load) begin
            cur       <= base;
            frm_start <= base;
            arr_ofs_q <= arr_ofs;
            frm_ofs_q <= frm_ofs;
        end else if (step && !hold) begin
            if (last_arr) begin
                cur       <= nxt_frame;
                frm_start <= nxt_frame;
            end else begin
                cur <= cur + arr_ext;
            end
        end
    end

    AST_CONST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !load |=> $stable(addr)); // R8
endmodule

// File: rtl/dma3d_walker.sv
// Module: dma3d_walker (top)
// Walks one descriptor across arrays, frames and a block, issuing one
// address/length request per array. Latches option fields on load; the
// load is refused while a block is in progress.
module dma3d_walker
    import dw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int OFS_W  = 16,
    parameter int OPT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  desc_load,
    input  logic [OPT_W-1:0]      desc_opt,
    input  logic [ADDR_W-1:0]     desc_src,
    input  logic [ADDR_W-1:0]     desc_dst,
    input  logic [CNT_W-1:0]      desc_acnt,
    input  logic [CNT_W-1:0]      desc_bcnt,
    input  logic [CNT_W-1:0]      desc_ccnt,
    input  logic [CNT_W-1:0]      desc_brld,
    input  logic [2*OFS_W-1:0]    desc_aofs,
    input  logic [2*OFS_W-1:0]    desc_fofs,
    input  logic                  sync_evt,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [ADDR_W-1:0]     req_src,
    output logic [ADDR_W-1:0]     req_dst,
    output logic [CNT_W-1:0]      req_len,
    output logic                  req_dst_const,
    output logic [OPT_FW_W-1:0]   req_fifo_width,
    output logic                  done_strobe,
    output logic [OPT_CODE_W-1:0] done_code,
    output logic                  busy
);
    localparam int NDIR = 2;   // 0 = source, 1 = destination

    logic                  load_ok, step, last_arr, last_frm;
    logic                  frame_sync_q, dst_const_q, done_en_q;
    logic [OPT_FW_W-1:0]   fw_q;
    logic [OPT_CODE_W-1:0] code_q;
    logic [CNT_W-1:0]      acnt_q;
    logic [ADDR_W-1:0]     base_v [NDIR];
    logic [ADDR_W-1:0]     addr_v [NDIR];
    logic                  hold_v [NDIR];

    // Latch the option fields and array length with the descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_sync_q <= 1'b0;
            dst_const_q  <= 1'b0;
            done_en_q    <= 1'b0;
            fw_q         <= '0;
            code_q       <= '0;
            acnt_q       <= '0;
        end else if (load_ok) begin
            frame_sync_q <= desc_opt[OPT_FRAME_SYNC];
            dst_const_q  <= desc_opt[OPT_DST_CONST];
            done_en_q    <= desc_opt[OPT_DONE_EN];
            fw_q         <= desc_opt[OPT_FW_LSB +: OPT_FW_W];
            code_q       <= desc_opt[OPT_CODE_LSB +: OPT_CODE_W];
            acnt_q       <= desc_acnt;
        end
    end

    // Per-direction base and hold selection
    always_comb begin
        base_v[0] = desc_src;
        base_v[1] = desc_dst;
        hold_v[0] = 1'b0;
        hold_v[1] = dst_const_q;
    end

    dw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_load   (desc_load),
        .sync_evt    (sync_evt),
        .req_ready   (req_ready),
        .last_arr    (last_arr),
        .last_frm    (last_frm),
        .frame_sync  (frame_sync_q),
        .done_en     (done_en_q),
        .load_ok     (load_ok),
        .step        (step),
        .req_valid   (req_valid),
        .busy        (busy),
        .done_strobe (done_strobe)
    );

    dw_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ok),
        .bcnt       (desc_bcnt),
        .ccnt       (desc_ccnt),
        .brld       (desc_brld),
        .frame_sync (frame_sync_q),
        .step       (step),
        .active     (busy),
        .last_arr   (last_arr),
        .last_frm   (last_frm)
    );

    // One walker per direction; offsets come from the matching half-word
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dw_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_ok),
            .base       (base_v[d]),
            .arr_ofs    (desc_aofs[d*OFS_W +: OFS_W]),
            .frm_ofs    (desc_fofs[d*OFS_W +: OFS_W]),
            .frame_sync (frame_sync_q),
            .hold       (hold_v[d]),
            .step       (step),
            .last_arr   (last_arr),
            .addr       (addr_v[d])
        );
    end

    // Request and completion outputs
    always_comb begin
        req_src        = addr_v[0];
        req_dst        = addr_v[1];
        req_len        = acnt_q;
        req_dst_const  = dst_const_q;
        req_fifo_width = fw_q;
        done_code      = code_q;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(req_src) && $stable(req_dst)); // R2
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy); // R11
endmodule

// File: tb/dma3d_walker_tb.sv
module dma3d_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [31:0] desc_opt = '0, desc_src = '0, desc_dst = '0;
    logic [15:0] desc_acnt = '0, desc_bcnt = '0, desc_ccnt = '0, desc_brld = '0;
    logic [31:0] desc_aofs = '0, desc_fofs = '0;
    logic        sync_evt = 1'b0, req_ready = 1'b0;
    logic        req_valid, req_dst_const, done_strobe, busy;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_len;
    logic [2:0]  req_fifo_width;
    logic [5:0]  done_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma3d_walker u_dut (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_opt(desc_opt),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_acnt(desc_acnt),
        .desc_bcnt(desc_bcnt), .desc_ccnt(desc_ccnt), .desc_brld(desc_brld),
        .desc_aofs(desc_aofs), .desc_fofs(desc_fofs), .sync_evt(sync_evt),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_dst(req_dst), .req_len(req_len), .req_dst_const(req_dst_const),
        .req_fifo_width(req_fifo_width), .done_strobe(done_strobe),
        .done_code(done_code), .busy(busy)
    );

    // Vector table: option, src, dst, acnt, bcnt, ccnt, brld, array ofs, frame ofs
    localparam int NV = 4;
    localparam logic [31:0] V_OPT [NV] = '{32'h0010_5000, 32'h0012_A001, 32'h0000_0502, 32'h0013_F001};
    localparam logic [31:0] V_SRC [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
    localparam logic [31:0] V_DST [NV] = '{32'h8000, 32'h9000, 32'hA000, 32'hB000};
    localparam logic [15:0] V_ACNT[NV] = '{16'd4, 16'd16, 16'd1, 16'd8};
    localparam logic [15:0] V_BCNT[NV] = '{16'd3, 16'd2, 16'd2, 16'd3};
    localparam logic [15:0] V_CCNT[NV] = '{16'd2, 16'd3, 16'd2, 16'd1};
    localparam logic [15:0] V_BRLD[NV] = '{16'd2, 16'd7, 16'd1, 16'd5};
    localparam logic [31:0] V_AOFS[NV] = '{32'h0008_0004, 32'h0010_FFFC, 32'h0004_0002, 32'h0};
    localparam logic [31:0] V_FOFS[NV] = '{32'hFFF0_0020, 32'h0040_0100, 32'h0010_0030, 32'h0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIAL_TAG %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic pulse_evt();
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
    endtask

    task automatic load_desc(input logic [31:0] opt, src, dst, input logic [15:0] a, b, c, r,
                             input logic [31:0] ao, fo);
        desc_opt = opt; desc_src = src; desc_dst = dst; desc_acnt = a;
        desc_bcnt = b; desc_ccnt = c; desc_brld = r; desc_aofs = ao; desc_fofs = fo;
        desc_load = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
    endtask

    // Walk one table vector against a model built from the requirements
    task automatic run_vec(input int i);
        logic        fmode, dconst, en;
        logic [31:0] s_cur, s_frm, d_cur, d_frm, hold_s;
        int          nb;
        fmode  = V_OPT[i][0];
        dconst = V_OPT[i][1];
        en     = V_OPT[i][20];
        s_cur = V_SRC[i]; s_frm = V_SRC[i]; d_cur = V_DST[i]; d_frm = V_DST[i];
        load_desc(V_OPT[i], V_SRC[i], V_DST[i], V_ACNT[i], V_BCNT[i], V_CCNT[i],
                  V_BRLD[i], V_AOFS[i], V_FOFS[i]);
        chk("R11 busy low before first event", {31'b0, busy}, 32'd0);
        for (int f = 0; f < int'(V_CCNT[i]); f++) begin
            nb = (f == 0 || fmode) ? int'(V_BCNT[i]) : int'(V_BRLD[i]);   // R7
            if (fmode) pulse_evt();
            for (int a = 0; a < nb; a++) begin
                if (!fmode) pulse_evt();
                chk(fmode ? "R4 frame array issued" : "R3 array issued", {31'b0, req_valid}, 32'd1);
                if (a == 0 && f == 0) begin
                    hold_s = req_src;
                    @(negedge clk);
                    chk("R2 valid held under stall", {31'b0, req_valid}, 32'd1);
                    chk("R2 src stable under stall", req_src, hold_s);
                    chk("R11 busy while active", {31'b0, busy}, 32'd1);
                end
                chk("R5 R6 src address", req_src, s_cur);
                chk(dconst ? "R8 dst constant" : "R5 R6 dst address", req_dst, d_cur);
                chk("R2 length", {16'b0, req_len}, {16'b0, V_ACNT[i]});
                chk("R8 fifo flag", {31'b0, req_dst_const}, {31'b0, dconst});
                chk("R8 fifo width", {29'b0, req_fifo_width}, {29'b0, V_OPT[i][10:8]});
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                // Advance model
                if (a == nb - 1) begin
                    s_cur = (fmode ? s_frm : s_cur) + sx(V_FOFS[i][15:0]);
                    s_frm = s_cur;
                    if (!dconst) begin
                        d_cur = (fmode ? d_frm : d_cur) + sx(V_FOFS[i][31:16]);
                        d_frm = d_cur;
                    end
                end else begin
                    s_cur = s_cur + sx(V_AOFS[i][15:0]);
                    if (!dconst) d_cur = d_cur + sx(V_AOFS[i][31:16]);
                end
                if (f == int'(V_CCNT[i]) - 1 && a == nb - 1) begin
                    chk("R9 done strobe", {31'b0, done_strobe}, {31'b0, en});
                    if (en) chk("R9 done code", {26'b0, done_code}, {26'b0, V_OPT[i][17:12]});
                    chk("R11 busy low at completion", {31'b0, busy}, 32'd0);
                end else if (!fmode) begin
                    chk("R3 one array per event", {31'b0, req_valid}, 32'd0);
                end else if (a == nb - 1) begin
                    chk("R4 wait after frame", {31'b0, req_valid}, 32'd0);
                    chk("R11 busy between frames", {31'b0, busy}, 32'd1);
                end
            end
        end
        @(negedge clk);
        chk("R9 strobe one cycle", {31'b0, done_strobe}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 no request in reset", {31'b0, req_valid}, 32'd0);
        chk("R1 not busy in reset", {31'b0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no request after reset", {31'b0, req_valid}, 32'd0);
        chk("R1 no done after reset", {31'b0, done_strobe}, 32'd0);
        chk("R1 not busy after reset", {31'b0, busy}, 32'd0);

        // R10: event with nothing armed is ignored
        pulse_evt();
        @(negedge clk);
        chk("R10 idle event ignored", {31'b0, req_valid}, 32'd0);
        chk("R10 idle event no busy", {31'b0, busy}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: second event while first request stalls is remembered
        load_desc(32'h0010_1000, 32'h500, 32'h600, 16'd2, 16'd2, 16'd1, 16'd1,
                  32'h0002_0002, 32'h0);
        pulse_evt();
        chk("R10 first request", {31'b0, req_valid}, 32'd1);
        pulse_evt();
        chk("R10 first request still stalled", req_src, 32'h500);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R10 gap after handshake", {31'b0, req_valid}, 32'd0);
        @(negedge clk);
        chk("R10 pending releases request", {31'b0, req_valid}, 32'd1);
        chk("R10 pending request address", req_src, 32'h502);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R10 done after pending", {31'b0, done_strobe}, 32'd1);
        chk("R9 code 1", {26'b0, done_code}, 32'd1);
        pulse_evt();
        @(negedge clk);
        chk("R10 event after completion ignored", {31'b0, req_valid}, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule